// File: doc/BRIEF.md
# Six-by-Six Fixed-Point Matrix Multiplier

The block forms the product C = A x B of two 6x6 matrices of signed 16-bit elements. Elements are written one at a time through a load port that addresses them by row and column. Elements of A are placed in six row banks, one bank per row. Elements of B are placed in six column banks, one bank per column, so B is transposed as it is written and the compute phase has no separate transpose step. Loaded elements stay in place until they are overwritten. Because of this, one operand can be kept and only the other reloaded between runs.

A start pulse begins the computation. For each row of A, six multiply-accumulate lanes run at the same time, one lane per column of B. Each lane issues one product per cycle into a registered multiplier stage and sums the products in a 36-bit accumulator. After six issue cycles and one cycle of pipeline drain, the six sums of that row are pushed one by one into an output FIFO with a ready/valid interface. A done pulse marks the cycle after the last result has entered the FIFO.

Top module: `matmul6`

## Requirements
- R1: While reset is held and after it is released, busy, done and out_valid are all low.
- R2: Each result equals the exact sum over k of A[i][k]*B[k][j]. The operands are signed 16-bit two's-complement values and the result is a signed 36-bit two's-complement value on out_data.
- R3: One run delivers exactly 36 results in row-major order. The result at index i*6+j is C[i][j], so all six columns of row i leave in order 0 to 5 before any result of row i+1.
- R4: A load with ld_sel=0 writes A[ld_row][ld_col]. A load with ld_sel=1 writes B[ld_row][ld_col]. Each element keeps its value until it is overwritten, so a run after reloading only B uses the A held from before.
- R5: Inputs at the extreme value -32768 in every element give 6442450944 in every result, with no overflow.
- R6: busy rises on the cycle after start is sampled while idle. The run produces exactly one done pulse, which lasts one cycle and comes with busy falling.
- R7: With out_ready held high, done is high 78 clock cycles after the edge that samples start (6 rows of 13 cycles each).
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data holds its value. A full FIFO stalls the engine, and no result is lost or duplicated.
- R9: A start pulse while busy has no effect. The run still yields 36 results, one done pulse, and the same 78-cycle timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_we | input | 1 | Element write strobe |
| ld_sel | input | 1 | 0 selects matrix A, 1 selects matrix B |
| ld_row | input | 3 | Row index of the written element (0..5) |
| ld_col | input | 3 | Column index of the written element (0..5) |
| ld_data | input | DW | Signed element value |
| start | input | 1 | Begins a multiply when idle |
| busy | output | 1 | High while a multiply is in progress |
| done | output | 1 | One-cycle pulse after the last result is queued |
| out_valid | output | 1 | FIFO holds a result |
| out_ready | input | 1 | Consumer accepts the result on out_data |
| out_data | output | ACCW | Head result of the FIFO |

## Verification
The bench builds the block with FIFO_DEPTH set to 4 and the default 16-bit operands and 36-bit accumulators. The shallow queue fills during the first row when out_ready is held low, so the stall path of the engine and the hold behaviour of the output are both exercised. The default widths bring the all-minimum-value case within reach as a direct test of accumulator headroom.

// File: rtl/matmul6.sv
module matmul6 #(
  parameter int DW         = 16,
  parameter int ACCW       = 36,
  parameter int FIFO_DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_we,
  input  logic            ld_sel,
  input  logic [2:0]      ld_row,
  input  logic [2:0]      ld_col,
  input  logic [DW-1:0]   ld_data,
  input  logic            start,
  output logic            busy,
  output logic            done,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [ACCW-1:0] out_data
);
  localparam int N   = 6;
  localparam int PRW = 2 * DW;
  localparam int PW  = $clog2(FIFO_DEPTH);
  localparam int CW  = $clog2(FIFO_DEPTH + 1);
  localparam logic [2:0] LAST = 3'(N - 1);
  localparam logic [2:0] NK   = 3'(N);

  typedef enum logic [1:0] {S_IDLE, S_MAC, S_PUSH} state_t;
  state_t state;

  logic signed [DW-1:0]   a_bank [N][N];
  logic signed [DW-1:0]   b_bank [N][N];
  logic signed [PRW-1:0]  prod   [N];
  logic signed [ACCW-1:0] acc    [N];
  logic [2:0] row, k, col;
  logic       pv, clr, push, pop, full;

  logic [ACCW-1:0] fmem [FIFO_DEPTH];
  logic [PW-1:0]   wp, rp;
  logic [CW-1:0]   fcnt;

  always_ff @(posedge clk)
    if (ld_we && ld_row < NK && ld_col < NK) begin
      if (!ld_sel) a_bank[ld_row][ld_col] <= ld_data;
      else         b_bank[ld_col][ld_row] <= ld_data;
    end

  assign busy      = state != S_IDLE;
  assign full      = fcnt == CW'(FIFO_DEPTH);
  assign push      = state == S_PUSH && !full;
  assign pop       = out_valid && out_ready;
  assign out_valid = fcnt != '0;
  assign out_data  = fmem[rp];
  assign clr       = (state == S_IDLE && start) ||
                     (push && col == LAST && row != LAST);

  for (genvar j = 0; j < N; j++) begin : g_lane
    always_ff @(posedge clk) begin
      if (state == S_MAC && k < NK)
        prod[j] <= a_bank[row][k] * b_bank[j][k];
      if (clr)
        acc[j] <= '0;
      else if (pv)
        acc[j] <= acc[j] + {{(ACCW-PRW){prod[j][PRW-1]}}, prod[j]};
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE;
      row   <= '0;
      k     <= '0;
      col   <= '0;
      pv    <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      pv   <= state == S_MAC && k < NK;
      case (state)
        S_IDLE:
          if (start) begin
            state <= S_MAC;
            row   <= '0;
            k     <= '0;
          end
        S_MAC: begin
          k <= k + 3'd1;
          if (k == NK) begin
            state <= S_PUSH;
            col   <= '0;
          end
        end
        S_PUSH:
          if (!full) begin
            col <= col + 3'd1;
            if (col == LAST) begin
              if (row == LAST) begin
                state <= S_IDLE;
                done  <= 1'b1;
              end else begin
                row   <= row + 3'd1;
                k     <= '0;
                state <= S_MAC;
              end
            end
          end
        default: state <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk)
    if (push) fmem[wp] <= acc[col];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fcnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(FIFO_DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == PW'(FIFO_DEPTH - 1)) ? '0 : rp + 1'b1;
      fcnt <= fcnt + CW'(push) - CW'(pop);
    end
endmodule

// File: rtl/matmul6_chk.sv
module matmul6_chk #(
  parameter int ACCW = 36
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            out_valid,
  input logic            out_ready,
  input logic [ACCW-1:0] out_data
);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_after_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind matmul6 matmul6_chk #(.ACCW(ACCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
);

// File: tb/matmul6_test.sv
module matmul6_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, ld_we = 1'b0, ld_sel = 1'b0, start = 1'b0, out_ready = 1'b1;
  logic [2:0] ld_row = '0, ld_col = '0;
  logic [15:0] ld_data = '0;
  logic busy, done, out_valid;
  logic [35:0] out_data;

  matmul6 #(.FIFO_DEPTH(4)) uut (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_sel(ld_sel), .ld_row(ld_row),
    .ld_col(ld_col), .ld_data(ld_data), .start(start), .busy(busy), .done(done),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  localparam int NCASE = 4;
  localparam int TV [NCASE][4] = '{
    '{1, 0, 1, 0},
    '{-37, 500, 113, -4000},
    '{2047, -31000, -1500, 9000},
    '{0, -32768, 0, -32768}
  };

  int checks = 0, fails = 0, ngot = 0, ndone = 0;
  bit finished = 1'b0;
  logic signed [15:0] ma [6][6];
  logic signed [15:0] mb [6][6];
  logic [35:0] got [64];
  logic hold_d = 1'b0;
  logic [35:0] hold_v = '0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (hold_d) chk(out_valid && out_data == hold_v, "R8 hold", longint'(out_data), longint'(hold_v));
      if (out_valid && out_ready && ngot < 64) begin
        got[ngot] = out_data;
        ngot++;
      end
      if (done) ndone++;
    end
    hold_d = out_valid && !out_ready;
    hold_v = out_data;
  end

  function automatic logic signed [15:0] gen(input int mul, input int off, input int r, input int c);
    return 16'(mul * (r * 6 + c) + off);
  endfunction

  task automatic fill(input int cs, input bit only_b);
    for (int r = 0; r < 6; r++)
      for (int c = 0; c < 6; c++) begin
        if (!only_b) ma[r][c] = gen(TV[cs][0], TV[cs][1], r, c);
        mb[r][c] = gen(TV[cs][2], TV[cs][3], r, c);
      end
  endtask

  task automatic load(input bit sel);
    for (int r = 0; r < 6; r++)
      for (int c = 0; c < 6; c++) begin
        @(posedge clk); #1;
        ld_we = 1'b1; ld_sel = sel; ld_row = 3'(r); ld_col = 3'(c);
        ld_data = sel ? mb[r][c] : ma[r][c];
      end
    @(posedge clk); #1;
    ld_we = 1'b0;
  endtask

  task automatic run(input string req, input bit bp, input bit restart);
    int n;
    longint e;
    ngot = 0; ndone = 0;
    @(posedge clk); #1;
    start = 1'b1; out_ready = !bp;
    @(posedge clk); #1;
    start = 1'b0;
    n = 0;
    while (!done && n < 2000) begin
      if (restart && n == 20) start = 1'b1;
      if (restart && n == 21) start = 1'b0;
      if (bp) begin
        if (n == 39) chk(out_valid && busy, "R8 stall with full FIFO", longint'({out_valid, busy}), 3);
        out_ready = (n >= 40) && (n % 3 != 0);
      end
      @(posedge clk); #1;
      n++;
    end
    if (!bp) chk(n == 78, restart ? "R9 timing" : "R7 timing", n, 78);
    out_ready = 1'b1;
    repeat (10) @(posedge clk);
    #1;
    chk(ngot == 36, {req, " R3 count"}, ngot, 36);
    chk(ndone == 1, {req, " R6 done pulses"}, ndone, 1);
    chk(!busy && !out_valid, {req, " R6 idle after run"}, longint'({busy, out_valid}), 0);
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++) begin
        e = 0;
        for (int k = 0; k < 6; k++) e += longint'(ma[i][k]) * longint'(mb[k][j]);
        chk(longint'($signed(got[i * 6 + j])) == e, {req, " R2 R3 element"},
            longint'($signed(got[i * 6 + j])), e);
      end
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk(!busy && !done && !out_valid, "R1 in reset", longint'({busy, done, out_valid}), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(!busy && !done && !out_valid, "R1 after reset", longint'({busy, done, out_valid}), 0);

    for (int cs = 0; cs < NCASE; cs++) begin
      fill(cs, 1'b0);
      load(1'b0);
      load(1'b1);
      run(cs == 3 ? "R5 extremes" : "table", 1'b0, 1'b0);
    end
    chk(longint'($signed(got[0])) == 64'sd6442450944, "R5 extreme value",
        longint'($signed(got[0])), 64'sd6442450944);

    fill(1, 1'b0);
    load(1'b0);
    fill(2, 1'b1);
    load(1'b1);
    run("R4 reload B only", 1'b0, 1'b0);

    fill(2, 1'b0);
    load(1'b0);
    load(1'b1);
    run("R8 backpressure", 1'b1, 1'b0);

    run("R9 restart ignored", 1'b0, 1'b1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule